// File: doc/BRIEF.md
# Stereo Soft-Ramping Attenuator

This block scales the two channels of a 24-bit two's-complement audio stream by a linear gain code. Each channel has its own 8-bit target code, where 255 passes the sample unchanged and 0 silences it; in between the gain is code/255, that is 20·log10(code/255) dB. The applied code never jumps. When a target changes, or when the soft-mute control is raised, the applied code walks one step at a time toward its goal, and each step waits a fixed number of frames. That wait is 4, 8 or 16 frames, chosen by the sampling speed mode.

A frame is one stereo sample pair accepted on the input stream. The input and output are valid/ready streams with one register stage between them. A sample is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new frame is accepted. Ramp timing counts accepted frames only, so stalls stretch a ramp in time but do not change its length in frames. The gain controls (`tgt_left`, `tgt_right`, `smute`, `speed`) are plain levels, sampled on each accepted frame.

Top module: `stereo_soft_atten`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and both applied codes are 255, so the first frames pass through unchanged.
- R2: Each output sample equals input × code / 255, rounded toward zero, with the result limited to the 24-bit two's-complement range. Code 0 gives an output of exactly 0.
- R3: The two channels ramp independently. A change to one channel's target leaves the other channel's output untouched.
- R4: The step period is 4 frames when `speed` is 00, 8 frames when it is 01, 16 frames when it is 10, and 4 frames when it is 11. Take a settled channel whose target changes by one code before frame 0. Frames 0 to P-1 use the old code, and frame P uses the new code.
- R5: Raising `smute` with both codes at 255 brings the output to 0 after 1020 frames in mode 00 and after 4080 frames in mode 10. The frame just before that uses code 1.
- R6: While `smute` is high, the applied code of each channel never increases, and it falls one code per step period until it reaches 0.
- R7: Lowering `smute` ramps the code back up to the programmed target at the same per-step rate. This holds whether or not the descent has already reached 0; a reversal mid-ramp starts climbing on the next step.
- R8: Changing a target while a ramp is in progress redirects the ramp toward the new target without restarting the step timer.
- R9: The output holds its sample while stalled (`out_valid` high and `out_ready` low). During a stall `in_ready` is low, and frames that are not accepted do not advance the ramp.
- R10: Negative samples scale symmetrically. -8388608 at code 255 passes unchanged, and small negative products truncate toward zero (for example -1 at code 254 gives 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed | input | 2 | Speed mode: 00 normal, 01 double, 10 quad, 11 normal |
| smute | input | 1 | Soft mute request, ramps both channels to 0 |
| tgt_left | input | 8 | Left channel target gain code |
| tgt_right | input | 8 | Right channel target gain code |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame may be accepted |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Downstream accepts output frame |
| out_left | output | 24 | Left attenuated sample |
| out_right | output | 24 | Right attenuated sample |

## Verification
The only internal state is the applied code of each channel and the shared step timer, and both show up in the samples. A wrong applied code changes the very next output frame, because that frame is scaled by the code in force when it is accepted. A timer that runs early or late, or that restarts on a redirect, moves the frame at which the new level first appears by at least one frame. Each check therefore drives a full-scale sample and compares the output at the last frame before an expected step and at the first frame after it.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_SPARE  = 2'b11
  } speed_e;

  // log2 of the step-period multiplier for a speed code
  function automatic int unsigned step_shift(input logic [1:0] spd);
    case (speed_e'(spd))
      SPD_DOUBLE: return 1;
      SPD_QUAD:   return 2;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/atten_step_timer.sv
module atten_step_timer #(
  parameter int BASE_STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame,
  input  logic       busy,
  input  logic [1:0] speed,
  output logic       step
);
  import atten_pkg::*;

  localparam int MAX_PERIOD = BASE_STEP * 4;
  localparam int CNT_W      = $clog2(MAX_PERIOD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   last;

  always_comb begin
    last = (CNT_W+1)'((BASE_STEP << step_shift(speed)) - 1);
  end

  // >= keeps a shortened period after a mode change from overrunning
  assign step = frame && busy && ({1'b0, cnt} >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (frame) begin
      if (!busy || step) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/atten_ramp.sv
module atten_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt,
  input  logic              smute,
  input  logic              step,
  output logic [CODE_W-1:0] code,
  output logic              settled
);
  logic [CODE_W-1:0] goal;

  assign goal    = smute ? '0 : tgt;
  assign settled = (code == goal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '1;
    end else if (step && !settled) begin
      if (code < goal) code <= code + 1'b1;
      else             code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/atten_gain.sv
module atten_gain #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8
) (
  input  logic [DATA_W-1:0] smp,
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] res
);
  localparam int PROD_W = DATA_W + CODE_W;
  localparam logic [PROD_W-1:0] FULL    = PROD_W'((64'd1 << CODE_W) - 64'd1);
  localparam logic [PROD_W-1:0] POS_LIM = PROD_W'((64'd1 << (DATA_W-1)) - 64'd1);
  localparam logic [PROD_W-1:0] NEG_LIM = PROD_W'(64'd1 << (DATA_W-1));

  logic              neg;
  logic [DATA_W-1:0] mag;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [PROD_W-1:0] lim;

  always_comb begin
    neg  = smp[DATA_W-1];
    mag  = neg ? (~smp + 1'b1) : smp;
    prod = {{CODE_W{1'b0}}, mag} * {{DATA_W{1'b0}}, code};
    quot = prod / FULL;
    if (neg) lim = (quot > NEG_LIM) ? NEG_LIM : quot;
    else     lim = (quot > POS_LIM) ? POS_LIM : quot;
    res  = neg ? (~lim[DATA_W-1:0] + 1'b1) : lim[DATA_W-1:0];
  end
endmodule

// File: rtl/stereo_soft_atten.sv
module stereo_soft_atten #(
  parameter int DATA_W    = 24,
  parameter int CODE_W    = 8,
  parameter int BASE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed,
  input  logic              smute,
  input  logic [CODE_W-1:0] tgt_left,
  input  logic [CODE_W-1:0] tgt_right,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  localparam int NUM_CH = 2;

  logic                           fire;
  logic                           step;
  logic                           busy;
  logic [NUM_CH-1:0]              settled;
  logic [NUM_CH-1:0][CODE_W-1:0]  tgt;
  logic [NUM_CH-1:0][CODE_W-1:0]  lvl;
  logic [NUM_CH-1:0][DATA_W-1:0]  smp_in;
  logic [NUM_CH-1:0][DATA_W-1:0]  smp_att;
  logic [NUM_CH-1:0][DATA_W-1:0]  smp_q;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign busy     = ~&settled;

  assign tgt[0]    = tgt_left;
  assign tgt[1]    = tgt_right;
  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;

  atten_step_timer #(.BASE_STEP(BASE_STEP)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .frame (fire),
    .busy  (busy),
    .speed (speed),
    .step  (step)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    atten_ramp #(.CODE_W(CODE_W)) i_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt     (tgt[ch]),
      .smute   (smute),
      .step    (step),
      .code    (lvl[ch]),
      .settled (settled[ch])
    );

    atten_gain #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_gain (
      .smp  (smp_in[ch]),
      .code (lvl[ch]),
      .res  (smp_att[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      smp_q     <= '0;
    end else begin
      if (fire)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (fire)           smp_q     <= smp_att;
    end
  end

  assign out_left  = smp_q[0];
  assign out_right = smp_q[1];
endmodule

// File: rtl/atten_chk.sv
module atten_chk #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smute,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [DATA_W-1:0]        in_left,
  input logic [DATA_W-1:0]        in_right,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [DATA_W-1:0]        out_left,
  input logic [DATA_W-1:0]        out_right,
  input logic [1:0][CODE_W-1:0]   lvl
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_LEVEL_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (lvl[0] == $past(lvl[0]) || lvl[0] == $past(lvl[0]) + 1 || lvl[0] + 1 == $past(lvl[0]))); // R4
  AST_LEVEL_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !acc |=> $stable(lvl)); // R9
  AST_MUTE_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n) smute |=> (lvl[0] <= $past(lvl[0]) && lvl[1] <= $past(lvl[1]))); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right))); // R9
  AST_ZERO_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (acc && lvl[1] == '0) |=> (out_right == '0)); // R2
  AST_FULL_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (acc && lvl[0] == '1) |=> (out_left == $past(in_left))); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (acc && !in_right[DATA_W-1]) |=> !out_right[DATA_W-1]); // R2
  AST_NEG_STAYS_NEG: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_left[DATA_W-1]) |=> (out_left[DATA_W-1] || out_left == '0)); // R10
endmodule

bind stereo_soft_atten atten_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) i_atten_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smute     (smute),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right),
  .lvl       (lvl)
);

// File: tb/test_stereo_soft_atten.sv
`timescale 1ns/1ps
module test_stereo_soft_atten;
  localparam logic [23:0] XP = 24'h7FFFFF;
  localparam logic [23:0] XN = 24'h800000;
  localparam logic [23:0] XR = 24'h123456;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  speed = 2'b00;
  logic        smute = 1'b0;
  logic [7:0]  tgt_left = 8'd255;
  logic [7:0]  tgt_right = 8'd255;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left;
  logic [23:0] out_right;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stereo_soft_atten i_stereo_soft_atten (
    .clk(clk), .rst_n(rst_n), .speed(speed), .smute(smute),
    .tgt_left(tgt_left), .tgt_right(tgt_right),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  function automatic logic [23:0] att(input logic [23:0] x, input int code);
    longint sx = longint'(signed'(x));
    longint q  = (sx * code) / 255;
    return q[23:0];
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one accepted frame, outputs readable on return
  task automatic put(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", {23'd0, out_valid}, 24'd0);
    chk("R1 in_ready", {23'd0, in_ready}, 24'd1);
    put(XP, XN);
    chk("R1 left pass", out_left, XP);
    chk("R1 right pass", out_right, XN);
  endtask

  task automatic t_step(input logic [1:0] spd, input int nt, input int from, input int per);
    speed = spd; tgt_left = 8'(nt);
    for (int i = 0; i <= per; i++) begin
      put(XP, XR);
      if (i == per - 1) chk("R4 before step", out_left, att(XP, from));
      if (i == per) begin
        chk("R4 after step", out_left, att(XP, nt));
        chk("R3 right untouched", out_right, XR);
      end
    end
  endtask

  task automatic t_settle_full();
    speed = 2'b00; tgt_left = 8'd255;
    for (int i = 0; i < 20; i++) put(XP, XP);
    chk("R4 back at 255", out_left, XP);
  endtask

  task automatic t_full(input logic [1:0] spd, input int per);
    int total = 255 * per;
    speed = spd; smute = 1'b1;
    for (int i = 0; i <= total; i++) begin
      put(XP, XP);
      if (i == total - 1) begin
        chk("R5 code 1 left", out_left, att(XP, 1));
        chk("R5 code 1 right", out_right, att(XP, 1));
      end
      if (i == total) begin
        chk("R5 muted left", out_left, 24'd0);
        chk("R2 muted right", out_right, 24'd0);
      end
    end
    smute = 1'b0;
    for (int i = 0; i <= total; i++) begin
      put(XP, XP);
      if (i == total - 1) chk("R7 climb 254", out_left, att(XP, 254));
      if (i == total)     chk("R7 climb done", out_right, XP);
    end
  endtask

  task automatic t_midrelease();
    speed = 2'b00; smute = 1'b1;
    for (int i = 0; i <= 80; i++) begin
      if (i == 40) smute = 1'b0;
      put(XP, XP);
      if (i == 39) chk("R6 descent 246", out_left, att(XP, 246));
      if (i == 40) chk("R7 reversal 245", out_left, att(XP, 245));
      if (i == 44) chk("R7 climb 246", out_left, att(XP, 246));
      if (i == 80) chk("R7 restored", out_left, XP);
    end
  endtask

  task automatic t_redirect();
    speed = 2'b00; tgt_left = 8'd250;
    for (int i = 0; i <= 8; i++) begin
      if (i == 6) tgt_left = 8'd255;
      put(XP, XP);
      if (i == 7) chk("R8 still 254", out_left, att(XP, 254));
      if (i == 8) chk("R8 timer kept", out_left, XP);
    end
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_left = 24'h100000; in_right = 24'h100000;
    @(negedge clk);
    in_left = 24'h200000; in_right = 24'h200000;
    for (int i = 0; i < 3; i++) begin
      chk("R9 stall ready low", {23'd0, in_ready}, 24'd0);
      chk("R9 stall hold", out_left, 24'h100000);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 drain next", out_left, 24'h200000);
  endtask

  task automatic t_negative();
    speed = 2'b00; tgt_left = 8'd254;
    for (int i = 0; i <= 4; i++) begin
      put(XN, 24'hFFFFFF);
      if (i == 4) begin
        chk("R10 neg full scale", out_left, att(XN, 254));
        chk("R10 right -1 at 255", out_right, 24'hFFFFFF);
      end
    end
    put(24'hFFFFFF, XN);
    chk("R10 -1 truncates", out_left, 24'd0);
    chk("R10 min at 255", out_right, XN);
    put(24'd255, XP);
    chk("R2 exact product", out_left, 24'd254);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step(2'b00, 254, 255, 4);
    t_step(2'b01, 253, 254, 8);
    t_step(2'b10, 252, 253, 16);
    t_step(2'b11, 251, 252, 4);
    t_settle_full();
    t_full(2'b00, 4);
    t_full(2'b10, 16);
    t_midrelease();
    t_redirect();
    t_backpressure();
    t_negative();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule